// File: doc/BRIEF.md
# Programmable Region Address Decoder

This block routes each memory request of a small system controller to one target: SDRAM, the general-purpose (GP) peripheral bus, ROM, the PCI bus, the on-chip configuration-register window or the boot window. Each request carries a 32-bit byte address and a 2-bit initiator code. The block answers one clock after the request with a target code, a one-hot GP chip-select vector and three flags: noncacheable, write-protect and error.

Default routing depends on a top-of-SDRAM page boundary supplied on an input. Sixteen programmable region registers, written one whole word at a time through a simple write port, can override the default for the CPU. All sixteen are compared in parallel. The lowest-numbered enabled register that matches wins.

Requests from a PCI master or the DMA engine never reach the GP bus, ROM or a PCI-targeted region. When a PCI master hits SDRAM space that a region register sends to the GP bus, the request stays in SDRAM with writes blocked.

Top module: `addr_route_unit`

## Requirements
- R1: Reset clears every output to zero, with rsp_dst = 0, meaning unclaimed. Reset also disables every region register, so only default routing applies until a register is written.
- R2: Each cycle with req_valid high gives rsp_valid high and the decoded result on the next clock edge. Each cycle with req_valid low gives rsp_valid low and all other outputs zero on the next edge.
- R3: Target codes on rsp_dst are 1 SDRAM, 2 GP, 3 ROM, 4 PCI, 5 configuration, 6 boot and 0 unclaimed. Initiator codes on req_init are 0 CPU, 1 PCI master, 2 DMA, with 3 treated as DMA. When no region register applies and page = req_addr[31:12] is below mem_top, every initiator goes to SDRAM.
- R4: When no region register applies and the page is at or above mem_top, the outcome depends on the initiator. A CPU goes to PCI. A PCI master is left unclaimed with code 0 and no error. A DMA request is unclaimed with rsp_err = 1.
- R5: For a CPU, page CFG_PAGE (default FFFEFh) goes to the configuration window and req_addr[31:16] = BOOT_SEG (default FFFFh) goes to the boot window. Both windows take priority over every region register. The same addresses from a PCI master are unclaimed; from DMA they are unclaimed with rsp_err = 1.
- R6: A region word on cfg_wdata has these fields: [47] enable, [46:45] target (0 GP, 1 ROM, 2 PCI, 3 reserved), [44] positive decode, [43:41] chip-select index, [39:20] base page and [19:0] size in 4-KiB pages. The word is written to register cfg_idx when cfg_we is high. A register matches when base ≤ page < base + size, so a size of 0 never matches. A CPU hit takes the target of the register.
- R7: When several enabled registers match, the one with the lowest index sets the result.
- R8: A CPU hit on a GP region gives rsp_dst = 2 and rsp_nc = 1. It also sets the rsp_cs bit given by the chip-select index, unless the positive-decode bit is set, in which case rsp_cs stays 0. Several registers may name one chip select. rsp_nc is set only for GP results.
- R9: GP and ROM regions match only pages below 40000h (1 GiB). Above that point the default routing applies.
- R10: Only registers 0 and 1 may select PCI. A PCI target in any other register, or the reserved target code in any register, disables that register, so a higher-numbered match can win instead.
- R11: For a PCI master, the region registers never change the target. When the winning match is a GP region and the page is below mem_top, the result is SDRAM with rsp_wp = 1. In every other case rsp_wp = 0.
- R12: For DMA, the region registers are ignored entirely and rsp_wp stays 0. rsp_err is set only for DMA requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Region register write strobe |
| cfg_idx | input | 4 | Region register index |
| cfg_wdata | input | 48 | Region register word (fields in R6) |
| mem_top | input | 20 | Top of SDRAM in 4-KiB pages |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| req_init | input | 2 | Initiator code (R3) |
| rsp_valid | output | 1 | Result valid |
| rsp_dst | output | 3 | Target code (R3) |
| rsp_cs | output | 8 | One-hot GP chip selects |
| rsp_nc | output | 1 | Noncacheable |
| rsp_wp | output | 1 | Write-protected SDRAM access |
| rsp_err | output | 1 | DMA access to an unreachable region |

## Verification
Directed patterns place addresses on both sides of each region edge, of the top-of-SDRAM boundary, of the 1-GiB line and of the two fixed windows. Comparing the results on each side separates an off-by-one in the range compare from a wrong boundary rule. Overlapping registers with mixed targets show whether priority goes to the lowest enabled legal index or to a disabled one. The same address is sent from all four initiator codes, which exposes any leak of GP, ROM or PCI routing to a PCI master or DMA, and any wrongly placed write-protect or error flag. Constrained random rounds then rewrite all sixteen registers with clustered bases and small sizes, some of them zero. They fire addresses near the programmed ranges and the windows, and check every result against a bench model.

// File: rtl/addr_route_pkg.sv
package addr_route_pkg;
    localparam int PG_W  = 20;
    localparam int CS_N  = 8;
    localparam int CS_W  = $clog2(CS_N);
    localparam int CFG_W = 48;

    typedef enum logic [1:0] {
        INIT_CPU = 2'd0,
        INIT_PCI = 2'd1,
        INIT_DMA = 2'd2,
        INIT_AUX = 2'd3
    } init_e;

    typedef enum logic [1:0] {
        RT_GP  = 2'd0,
        RT_ROM = 2'd1,
        RT_PCI = 2'd2,
        RT_RSV = 2'd3
    } rtgt_e;

    typedef enum logic [2:0] {
        DST_NONE  = 3'd0,
        DST_SDRAM = 3'd1,
        DST_GP    = 3'd2,
        DST_ROM   = 3'd3,
        DST_PCI   = 3'd4,
        DST_CFG   = 3'd5,
        DST_BOOT  = 3'd6
    } dst_e;

    typedef struct packed {
        logic            en;
        rtgt_e           tgt;
        logic            posdec;
        logic [CS_W-1:0] cs;
        logic            spare;
        logic [PG_W-1:0] base;
        logic [PG_W-1:0] size;
    } region_t;

    typedef struct packed {
        logic            valid;
        dst_e            dst;
        logic [CS_N-1:0] cs;
        logic            nc;
        logic            wp;
        logic            err;
    } resp_t;
endpackage

// File: rtl/region_cmp.sv
module region_cmp
    import addr_route_pkg::*;
#(
    parameter int              IDX       = 0,
    parameter int              PCI_SLOTS = 2,
    parameter logic [PG_W-1:0] LOW_PG    = 20'h40000
) (
    input  region_t         cfg,
    input  logic [PG_W-1:0] page,
    output logic            hit
);
    localparam bit PCI_OK = (IDX < PCI_SLOTS);

    logic [PG_W:0] lim;
    logic          in_rng;
    logic          legal;
    logic          low_ok;

    always_comb begin
        lim    = {1'b0, cfg.base} + {1'b0, cfg.size};
        in_rng = (page >= cfg.base) && ({1'b0, page} < lim);
        legal  = 1'b0;
        low_ok = 1'b1;
        case (cfg.tgt)
            RT_GP, RT_ROM: begin
                legal  = 1'b1;
                low_ok = (page < LOW_PG);
            end
            RT_PCI:  legal = PCI_OK;
            default: legal = 1'b0;
        endcase
        hit = cfg.en && legal && low_ok && in_rng;
    end
endmodule

// File: rtl/first_hit.sv
module first_hit #(
    parameter int N = 16
) (
    input  logic [N-1:0]         hits,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/addr_route_unit.sv
module addr_route_unit
    import addr_route_pkg::*;
#(
    parameter int              N_REG     = 16,
    parameter int              PCI_SLOTS = 2,
    parameter logic [PG_W-1:0] CFG_PAGE  = 20'hFFFEF,
    parameter logic [15:0]     BOOT_SEG  = 16'hFFFF,
    parameter logic [PG_W-1:0] LOW_PG    = 20'h40000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [$clog2(N_REG)-1:0] cfg_idx,
    input  logic [CFG_W-1:0]         cfg_wdata,
    input  logic [PG_W-1:0]          mem_top,
    input  logic                     req_valid,
    input  logic [31:0]              req_addr,
    input  logic [1:0]               req_init,
    output logic                     rsp_valid,
    output logic [2:0]               rsp_dst,
    output logic [CS_N-1:0]          rsp_cs,
    output logic                     rsp_nc,
    output logic                     rsp_wp,
    output logic                     rsp_err
);
    localparam int IW = $clog2(N_REG);

    typedef struct packed {
        region_t [N_REG-1:0] regs;
        resp_t               rsp;
    } state_t;

    state_t          st_q, st_d;
    logic [PG_W-1:0] page;
    logic [N_REG-1:0] hits;
    logic            any_hit;
    logic [IW-1:0]   sel_idx;
    region_t         sel;
    logic            unused_ok;

    assign page      = req_addr[31:12];
    assign unused_ok = ^req_addr[11:0];

    // One comparator per region register
    for (genvar g = 0; g < N_REG; g++) begin : g_cmp
        region_cmp #(
            .IDX      (g),
            .PCI_SLOTS(PCI_SLOTS),
            .LOW_PG   (LOW_PG)
        ) i_cmp (
            .cfg (st_q.regs[g]),
            .page(page),
            .hit (hits[g])
        );
    end

    first_hit #(.N(N_REG)) i_pick (
        .hits(hits),
        .any (any_hit),
        .idx (sel_idx)
    );

    assign sel = st_q.regs[sel_idx];

    always_comb begin
        logic  cpu, pci, below, cfg_hit, boot_hit;
        resp_t r;

        st_d = st_q;
        if (cfg_we) st_d.regs[cfg_idx] = region_t'(cfg_wdata);

        cpu      = (req_init == INIT_CPU);
        pci      = (req_init == INIT_PCI);
        below    = (page < mem_top);
        cfg_hit  = (page == CFG_PAGE);
        boot_hit = (req_addr[31:16] == BOOT_SEG);

        r     = '0;
        r.dst = DST_NONE;
        if (cfg_hit || boot_hit) begin
            // fixed windows outrank every region register
            if (cpu)       r.dst = cfg_hit ? DST_CFG : DST_BOOT;
            else if (!pci) r.err = 1'b1;
        end else if (cpu && any_hit) begin
            case (sel.tgt)
                RT_GP: begin
                    r.dst = DST_GP;
                    r.nc  = 1'b1;
                    if (!sel.posdec) r.cs[sel.cs] = 1'b1;
                end
                RT_ROM:  r.dst = DST_ROM;
                default: r.dst = DST_PCI;
            endcase
        end else if (below) begin
            r.dst = DST_SDRAM;
            r.wp  = pci && any_hit && (sel.tgt == RT_GP);
        end else if (cpu) begin
            r.dst = DST_PCI;
        end else if (!pci) begin
            r.err = 1'b1;
        end

        if (req_valid) begin
            r.valid = 1'b1;
        end else begin
            r     = '0;
            r.dst = DST_NONE;
        end
        st_d.rsp = r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp.valid;
    assign rsp_dst   = st_q.rsp.dst;
    assign rsp_cs    = st_q.rsp.cs;
    assign rsp_nc    = st_q.rsp.nc;
    assign rsp_wp    = st_q.rsp.wp;
    assign rsp_err   = st_q.rsp.err;
endmodule

// File: rtl/addr_route_chk.sv
module addr_route_chk
    import addr_route_pkg::*;
#(
    parameter logic [PG_W-1:0] CFG_PAGE = 20'hFFFEF
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [31:0]     req_addr,
    input logic [1:0]      req_init,
    input logic            rsp_valid,
    input logic [2:0]      rsp_dst,
    input logic [CS_N-1:0] rsp_cs,
    input logic            rsp_nc,
    input logic            rsp_wp,
    input logic            rsp_err
);
    p_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && rsp_dst == DST_NONE && rsp_cs == '0));
    p_cfg_win_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_init == INIT_CPU && req_addr[31:12] == CFG_PAGE)
        |=> rsp_dst == DST_CFG);
    p_cs_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cs));
    p_cs_gp_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_cs != '0) |-> rsp_dst == DST_GP);
    p_nc_gp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_nc == (rsp_valid && rsp_dst == DST_GP));
    p_gp_cpu_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_init != INIT_CPU) |=> !(rsp_dst inside {DST_GP, DST_ROM}));
    p_wp_pci_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_init != INIT_PCI) |=> !rsp_wp);
    p_wp_sdram_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wp |-> rsp_dst == DST_SDRAM);
    p_err_dma_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_init == INIT_CPU || req_init == INIT_PCI) |=> !rsp_err);
    p_err_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> rsp_dst == DST_NONE);
endmodule

bind addr_route_unit addr_route_chk #(.CFG_PAGE(CFG_PAGE)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_init (req_init),
    .rsp_valid(rsp_valid),
    .rsp_dst  (rsp_dst),
    .rsp_cs   (rsp_cs),
    .rsp_nc   (rsp_nc),
    .rsp_wp   (rsp_wp),
    .rsp_err  (rsp_err)
);

// File: tb/test_addr_route_unit.sv
`timescale 1ns/1ps
module test_addr_route_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [47:0] cfg_wdata = '0;
    logic [19:0] mem_top = 20'h08000;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_init = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_dst;
    logic [7:0]  rsp_cs;
    logic        rsp_nc, rsp_wp, rsp_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench copy of what was written
    bit          m_en [16];
    int          m_tgt[16];
    bit          m_pd [16];
    int          m_cs [16];
    logic [19:0] m_base[16];
    logic [19:0] m_size[16];

    addr_route_unit i_addr_route_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .mem_top(mem_top), .req_valid(req_valid),
        .req_addr(req_addr), .req_init(req_init), .rsp_valid(rsp_valid),
        .rsp_dst(rsp_dst), .rsp_cs(rsp_cs), .rsp_nc(rsp_nc),
        .rsp_wp(rsp_wp), .rsp_err(rsp_err)
    );

    always #10 clk = ~clk;

    function automatic bit reg_hit(int i, logic [19:0] pg);
        logic [20:0] lim;
        bit legal;
        lim   = {1'b0, m_base[i]} + {1'b0, m_size[i]};
        legal = ((m_tgt[i] == 0 || m_tgt[i] == 1) && pg < 20'h40000) ||
                (m_tgt[i] == 2 && i < 2);
        return m_en[i] && legal && pg >= m_base[i] && {1'b0, pg} < lim;
    endfunction

    // {dst[2:0], cs[7:0], nc, wp, err}
    function automatic logic [13:0] model(logic [31:0] a, int ini);
        logic [19:0] pg;
        int sel;
        logic [2:0] d;
        logic [7:0] cs;
        bit nc, wp, er, cpu, pci;
        pg = a[31:12];
        cpu = (ini == 0);
        pci = (ini == 1);
        sel = -1;
        for (int i = 15; i >= 0; i--) if (reg_hit(i, pg)) sel = i;
        d = 0; cs = 0; nc = 0; wp = 0; er = 0;
        if (pg == 20'hFFFEF || a[31:16] == 16'hFFFF) begin
            if (cpu) d = (pg == 20'hFFFEF) ? 3'd5 : 3'd6;
            else if (!pci) er = 1;
        end else if (cpu && sel >= 0) begin
            if (m_tgt[sel] == 0) begin
                d = 3'd2; nc = 1;
                if (!m_pd[sel]) cs[m_cs[sel]] = 1'b1;
            end else if (m_tgt[sel] == 1) d = 3'd3;
            else d = 3'd4;
        end else if (pg < mem_top) begin
            d = 3'd1;
            wp = pci && sel >= 0 && m_tgt[sel] == 0;
        end else if (cpu) d = 3'd4;
        else if (!pci) er = 1;
        return {d, cs, nc, wp, er};
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(int idx, bit en, int tgt, bit pd, int cs,
                      logic [19:0] base, logic [19:0] size);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 4'(idx);
        cfg_wdata = {en, 2'(tgt), pd, 3'(cs), 1'b0, base, size};
        m_en[idx] = en; m_tgt[idx] = tgt; m_pd[idx] = pd;
        m_cs[idx] = cs; m_base[idx] = base; m_size[idx] = size;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req(string tag, logic [31:0] a, int ini);
        logic [13:0] e;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_init  = 2'(ini);
        e = model(a, ini);
        @(negedge clk);
        check(tag, {17'd0, rsp_valid, rsp_dst, rsp_cs, rsp_nc, rsp_wp, rsp_err},
              {17'd0, 1'b1, e});
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            m_en[i] = 0; m_tgt[i] = 0; m_pd[i] = 0; m_cs[i] = 0;
            m_base[i] = 0; m_size[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset outputs", {26'd0, rsp_valid, rsp_dst, rsp_cs, rsp_nc, rsp_wp, rsp_err}, 32'd0);
        rst_n = 1'b1;
        req("R1 regs disabled after reset", 32'h0010_0000, 0);
        // R2 idle cycle
        @(negedge clk);
        check("R2 idle gives no result", {20'd0, rsp_valid, rsp_dst, rsp_cs}, 32'd0);
        // R3 default below top
        req("R3 pci below top", 32'h0000_1234, 1);
        req("R3 dma below top", 32'h07FF_F000, 2);
        // R4 above top
        req("R4 cpu above top", 32'h0800_0000, 0);
        req("R4 pci above top", 32'h1000_0000, 1);
        req("R4 dma above top", 32'h1000_0000, 2);
        // R5 windows
        wr(0, 1, 2, 0, 0, 20'hFFF00, 20'h000FF);
        req("R5 cfg window beats pci region", 32'hFFFE_F010, 0);
        req("R5 boot window", 32'hFFFF_8000, 0);
        req("R5 dma boot window", 32'hFFFF_0000, 2);
        req("R5 pci cfg window", 32'hFFFE_F000, 1);
        // R6 range edges
        wr(2, 1, 0, 0, 5, 20'h00100, 20'h00010);
        req("R6 base edge", 32'h0010_0000, 0);
        req("R6 last page", 32'h0010_FFFC, 0);
        req("R6 past end", 32'h0011_0000, 0);
        req("R6 below base", 32'h000F_F000, 0);
        wr(9, 1, 1, 0, 0, 20'h00500, 20'h0);
        req("R6 zero size", 32'h0050_0000, 0);
        // R7 priority
        wr(3, 1, 1, 0, 0, 20'h00100, 20'h00004);
        req("R7 lower index gp wins", 32'h0010_1000, 0);
        wr(1, 1, 1, 0, 0, 20'h00102, 20'h00001);
        req("R7 index1 rom wins", 32'h0010_2000, 0);
        // R8 positive decode and shared chip select
        wr(4, 1, 0, 1, 2, 20'h00200, 20'h00008);
        req("R8 positive decode", 32'h0020_3000, 0);
        wr(5, 1, 0, 0, 5, 20'h00300, 20'h00002);
        req("R8 shared cs", 32'h0030_1000, 0);
        // R9 1 GiB line
        mem_top = 20'h01000;
        wr(6, 1, 0, 0, 7, 20'h3FFFE, 20'h00004);
        req("R9 gp below 1G", 32'h3FFF_F000, 0);
        req("R9 gp at 1G", 32'h4000_0000, 0);
        req("R9 gp beyond 1G", 32'h4000_1000, 0);
        mem_top = 20'h08000;
        // R10 pci slots
        wr(7, 1, 2, 0, 0, 20'h00400, 20'h00010);
        req("R10 pci in reg7 disabled", 32'h0040_0000, 0);
        wr(0, 1, 2, 0, 0, 20'h000A0, 20'h00020);
        req("R10 pci in reg0", 32'h000A_5000, 0);
        wr(8, 1, 3, 0, 0, 20'h00600, 20'h00010);
        wr(10, 1, 1, 0, 0, 20'h00600, 20'h00010);
        req("R10 reserved code lets reg10 win", 32'h0060_0000, 0);
        // R11 pci master
        req("R11 pci on gp region", 32'h0010_0000, 1);
        req("R11 pci on rom region", 32'h0010_2000, 1);
        req("R11 pci on pci region", 32'h000A_5000, 1);
        req("R11 pci on gp above top", 32'h3FFF_F000, 1);
        // R12 dma
        req("R12 dma on gp region", 32'h0010_0000, 2);
        req("R12 aux code above top", 32'h2000_0000, 3);
        // constrained random rounds
        for (int rnd = 0; rnd < 8; rnd++) begin
            for (int i = 0; i < 16; i++) begin
                logic [19:0] b;
                int k;
                k = $urandom % 4;
                case (k)
                    0: b = 20'($urandom % 32'h10000);
                    1: b = 20'h07FF0 + 20'($urandom % 32);
                    2: b = 20'h3FFE0 + 20'($urandom % 64);
                    default: b = 20'hFFFE0 + 20'($urandom % 24);
                endcase
                wr(i, 1'($urandom % 4 != 0), $urandom % 4, 1'($urandom % 3 == 0),
                   $urandom % 8, b, 20'($urandom % 40));
            end
            mem_top = (rnd % 2 == 0) ? 20'h08000 : 20'h40000;
            for (int j = 0; j < 150; j++) begin
                logic [19:0] pg;
                int r;
                r  = $urandom % 16;
                pg = m_base[r] + 20'($urandom % (m_size[r] + 3)) - 20'd1;
                req("R6 R7 R8 R11 random", {pg, 12'($urandom)}, $urandom % 4);
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule